// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This peripheral holds four independent 32-bit down-counters behind a plain register bus. The bus has an address, a write strobe, write data and a combinational read-data return. Each channel repeats a period of programmable length. At the end of every period it sets a sticky interrupt flag, reloads and keeps counting. There is no one-shot mode, so software that wants a single event disables the channel from its interrupt handler. Each channel drives a level interrupt while its flag is set and its interrupt enable is on.

A global disable bit freezes every channel at once, and reset leaves it set. Any channel above channel 0 can be put in chained mode. A chained channel counts the expirations of the channel below it rather than clock cycles, so two 32-bit channels act as one 64-bit interval. A new load value written during a period does not disturb that period. It is used at the next reload, or at once after the channel is disabled and enabled again.

Top module: `pit_timer`

## Requirements
- R1: After reset the global control word reads 0x2 (disable bit set). Every channel control word, flag and load value reads 0, and all interrupt outputs are low.
- R2: While bit 1 of the global control word (byte address 0x000) is 1, no channel counter changes value. Clearing it lets enabled channels count from where they stopped.
- R3: Channel c (0..3) occupies byte addresses 0x100 + 16*c, with load at +0x0, current count at +0x4, control at +0x8 and flag at +0xC. Load reads back as written. Control reads back bits [2:0] only: bit 0 run, bit 1 interrupt enable, bit 2 chain.
- R4: A run bit that goes from 0 to 1 makes the counter take the load value L on the first enabled cycle. The counter then steps down by one per cycle, so the count sequence is L, L-1, ..., 0, L, ... and each period is L+1 cycles.
- R5: The cycle in which a counting channel leaves zero sets its flag (flag bit 0). Writing 1 to flag bit 0 clears it, writing 0 leaves it unchanged, and a flag stays set until cleared.
- R6: Interrupt output c is high exactly when channel c's flag is set and its interrupt enable bit is 1.
- R7: Writing the load value while a channel runs does not change its current count or the end of the current period. The new value is used at the next reload, and a run 0-then-1 sequence restarts from it.
- R8: A channel c>0 with the chain bit set steps only in cycles in which channel c-1 expires. It still takes its load value on its first enabled cycle. The chain bit of channel 0 has no effect.
- R9: The current-count register is read-only; writes to it do not change it.
- R10: Addresses outside the map, including misaligned ones and channel index 4 and above, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 4 | Per-channel level interrupt |

## Verification
The period is swept on every channel with load values 0, 1, 2 and 4. The count is read on every cycle across two periods, which separates a correct L+1 period from an off-by-one in the first load or in the reload. The flag and interrupt are read on the same cycles, so an early or late flag shows up as a mismatch. A chained pair with a 3-cycle lower period checks that the upper channel holds between the lower channel's expirations and expires on the second one. A mid-period load change and a global disable mid-count separate "takes effect at reload" and "freeze" from a restart or a lost count.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef enum logic [1:0] {
        REG_LOAD = 2'd0,
        REG_CURR = 2'd1,
        REG_CTRL = 2'd2,
        REG_FLAG = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic chain;
        logic irq_en;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W   = 3;
    localparam int unsigned GDIS_BIT = 1;
    localparam int unsigned CH_PAGE  = 1;
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
    import pit_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NCH    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              glb_hit,
    output logic [NCH-1:0]    ch_hit,
    output reg_sel_e          sel
);
    localparam int unsigned IDX_W = 4;

    logic             in_page;
    logic             aligned;
    logic [IDX_W-1:0] idx;

    always_comb begin
        glb_hit = (addr == '0);
        in_page = (addr[ADDR_W-1:8] == (ADDR_W-8)'(CH_PAGE));
        aligned = (addr[1:0] == 2'b00);
        idx     = addr[7:4];
        sel     = reg_sel_e'(addr[3:2]);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_hit
        assign ch_hit[i] = in_page && aligned && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter bit          HAS_PREV = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gbl_en,
    input  logic             prev_exp,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             wr_flag,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] cnt_o,
    output ctrl_t            ctrl_o,
    output logic             flag_o,
    output logic             started_o,
    output logic             exp_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        ctrl_t            ctrl;
        logic             flag;
        logic             started;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      step;
    logic      expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        step   = (st_q.ctrl.chain && HAS_PREV) ? prev_exp : 1'b1;

        if (gbl_en && st_q.ctrl.run) begin
            if (!st_q.started) begin
                st_d.cnt     = st_q.load;
                st_d.started = 1'b1;
            end else if (step) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = st_q.load;
                    expire   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
        if (!st_q.ctrl.run) begin
            st_d.started = 1'b0;
        end

        if (wr_load) begin
            st_d.load = wdata;
        end
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        end
        if (wr_flag && wdata[0]) begin
            st_d.flag = 1'b0;
        end
        if (expire) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o    = st_q.load;
    assign cnt_o     = st_q.cnt;
    assign ctrl_o    = st_q.ctrl;
    assign flag_o    = st_q.flag;
    assign started_o = st_q.started;
    assign exp_o     = expire;
    assign irq_o     = st_q.flag && st_q.ctrl.irq_en;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq_o
);
    logic                      gdis_d, gdis_q;
    logic                      glb_hit;
    logic [NCH-1:0]            ch_hit;
    reg_sel_e                  sel;
    logic [NCH-1:0][CNT_W-1:0] load_w;
    logic [NCH-1:0][CNT_W-1:0] cnt_w;
    ctrl_t [NCH-1:0]           ctrl_w;
    logic [NCH-1:0]            flag_w;
    logic [NCH-1:0]            started_w;
    logic [NCH-1:0]            exp_w;
    logic [NCH-1:0]            run_w;
    logic [NCH-1:0]            chain_w;

    pit_bus_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .addr    (bus_addr),
        .glb_hit (glb_hit),
        .ch_hit  (ch_hit),
        .sel     (sel)
    );

    always_comb begin
        gdis_d = gdis_q;
        if (bus_we && glb_hit) begin
            gdis_d = bus_wdata[GDIS_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gdis_q <= 1'b1;
        end else begin
            gdis_q <= gdis_d;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic prev;
        if (i == 0) begin : g_first
            assign prev = 1'b0;
        end else begin : g_rest
            assign prev = exp_w[i-1];
        end

        pit_channel #(.CNT_W(CNT_W), .HAS_PREV(i != 0)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .gbl_en    (!gdis_q),
            .prev_exp  (prev),
            .wr_load   (bus_we && ch_hit[i] && (sel == REG_LOAD)),
            .wr_ctrl   (bus_we && ch_hit[i] && (sel == REG_CTRL)),
            .wr_flag   (bus_we && ch_hit[i] && (sel == REG_FLAG)),
            .wdata     (bus_wdata[CNT_W-1:0]),
            .load_o    (load_w[i]),
            .cnt_o     (cnt_w[i]),
            .ctrl_o    (ctrl_w[i]),
            .flag_o    (flag_w[i]),
            .started_o (started_w[i]),
            .exp_o     (exp_w[i]),
            .irq_o     (irq_o[i])
        );

        assign run_w[i]   = ctrl_w[i].run;
        assign chain_w[i] = ctrl_w[i].chain;
    end

    always_comb begin
        bus_rdata = '0;
        if (glb_hit) begin
            bus_rdata[GDIS_BIT] = gdis_q;
        end
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                case (sel)
                    REG_LOAD: bus_rdata = DATA_W'(load_w[i]);
                    REG_CURR: bus_rdata = DATA_W'(cnt_w[i]);
                    REG_CTRL: bus_rdata = DATA_W'(ctrl_w[i]);
                    REG_FLAG: bus_rdata = DATA_W'(flag_w[i]);
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_we,
    input logic                      wbit0,
    input logic                      gdis,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0]            flag,
    input logic [NCH-1:0]            run,
    input logic [NCH-1:0]            chain,
    input logic [NCH-1:0]            started,
    input logic [NCH-1:0]            expd
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(256 + 16 * i + 12);
        localparam bit                FREE   = (i == 0);

        logic clr;
        logic live;
        logic self_clocked;
        assign clr          = bus_we && (bus_addr == FLAG_A) && wbit0;
        assign live         = !gdis && run[i] && started[i];
        assign self_clocked = FREE || !chain[i];

        AST_GDIS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            gdis |=> $stable(cnt[i])); // R2

        AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (live && self_clocked && cnt[i] != '0) |=> (cnt[i] == $past(cnt[i]) - 1'b1)); // R4

        AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (live && self_clocked && cnt[i] == '0) |=> flag[i]); // R5

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr) |=> flag[i]); // R5

        if (i > 0) begin : g_chain
            AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (live && chain[i] && !expd[i-1]) |=> $stable(cnt[i])); // R8
        end
    end
endmodule

bind pit_timer pit_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .wbit0    (bus_wdata[0]),
    .gdis     (gdis_q),
    .cnt      (cnt_w),
    .flag     (flag_w),
    .run      (run_w),
    .chain    (chain_w),
    .started  (started_w),
    .expd     (exp_w)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pit_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [11:0] ra(input int ch, input int r);
        return 12'(256 + 16 * ch + 4 * r);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);

        // R1: reset values
        expect_rd("R1 gctl", 12'h000, 32'h2);
        for (int c = 0; c < 4; c++) begin
            expect_rd("R1 ctrl", ra(c, 2), 32'h0);
            expect_rd("R1 flag", ra(c, 3), 32'h0);
            expect_rd("R1 load", ra(c, 0), 32'h0);
        end
        check("R1 irq", 32'(irq_o), 32'h0);

        // R3: register map readback while globally disabled
        for (int c = 0; c < 4; c++) begin
            wr(ra(c, 0), 32'hA500_0000 + 32'(c));
            wr(ra(c, 2), 32'hFFFF_FFF8 | 32'(c));
        end
        for (int c = 0; c < 4; c++) begin
            expect_rd("R3 load", ra(c, 0), 32'hA500_0000 + 32'(c));
            expect_rd("R3 ctrl", ra(c, 2), 32'(c));
        end
        // R2: enabled channels do not count while the global disable is set
        step(5);
        for (int c = 0; c < 4; c++) begin
            expect_rd("R2 held", ra(c, 1), 32'h0);
            expect_rd("R2 noflag", ra(c, 3), 32'h0);
            wr(ra(c, 2), 32'h0);
        end

        // R10: unmapped reads
        expect_rd("R10 gap", 12'h004, 32'h0);
        expect_rd("R10 gap", 12'h0FC, 32'h0);
        expect_rd("R10 ch4", 12'h140, 32'h0);
        expect_rd("R10 page", 12'h200, 32'h0);
        expect_rd("R10 misalign", 12'h102, 32'h0);

        wr(12'h000, 32'h0);
        expect_rd("R2 gctl", 12'h000, 32'h0);

        // R4 R5 R6: period sweep on every channel
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 4; k++) begin
                int n;
                n = (k == 3) ? 4 : k;
                wr(ra(c, 2), 32'h0);
                wr(ra(c, 3), 32'h1);
                wr(ra(c, 0), 32'(n));
                wr(ra(c, 2), 32'h3);
                for (int j = 1; j <= 2 * n + 4; j++) begin
                    step(1);
                    expect_rd("R4 count", ra(c, 1), 32'(n - ((j - 1) % (n + 1))));
                    expect_rd("R5 flag", ra(c, 3), (j >= n + 2) ? 32'h1 : 32'h0);
                    check("R6 irq", 32'(irq_o[c]), (j >= n + 2) ? 32'h1 : 32'h0);
                end
            end
            wr(ra(c, 2), 32'h0);
        end

        // R5 R6: write-one-clear and interrupt gating on a stopped channel
        expect_rd("R5 set", ra(2, 3), 32'h1);
        check("R6 ie off", 32'(irq_o[2]), 32'h0);
        wr(ra(2, 2), 32'h2);
        check("R6 ie on", 32'(irq_o[2]), 32'h1);
        wr(ra(2, 3), 32'h0);
        expect_rd("R5 w0", ra(2, 3), 32'h1);
        wr(ra(2, 3), 32'h1);
        expect_rd("R5 w1c", ra(2, 3), 32'h0);
        check("R6 cleared", 32'(irq_o[2]), 32'h0);
        wr(ra(2, 2), 32'h0);

        // R7: load change mid-period
        wr(ra(3, 0), 32'd9);
        wr(ra(3, 3), 32'h1);
        wr(ra(3, 2), 32'h1);
        step(3);
        expect_rd("R7 before", ra(3, 1), 32'd7);
        wr(ra(3, 0), 32'd3);
        expect_rd("R7 undisturbed", ra(3, 1), 32'd6);
        step(6);
        expect_rd("R7 end", ra(3, 1), 32'd0);
        expect_rd("R7 noflag", ra(3, 3), 32'h0);
        step(1);
        expect_rd("R7 reload", ra(3, 1), 32'd3);
        expect_rd("R7 flag", ra(3, 3), 32'h1);
        step(1);
        expect_rd("R7 next", ra(3, 1), 32'd2);
        wr(ra(3, 2), 32'h0);
        wr(ra(3, 0), 32'd5);
        wr(ra(3, 2), 32'h1);
        step(1);
        expect_rd("R7 restart", ra(3, 1), 32'd5);
        wr(ra(3, 2), 32'h0);

        // R2 R9: freeze mid-count, write to current count ignored
        wr(ra(2, 0), 32'd7);
        wr(ra(2, 2), 32'h1);
        step(2);
        expect_rd("R2 run", ra(2, 1), 32'd6);
        wr(12'h000, 32'h2);
        expect_rd("R2 last", ra(2, 1), 32'd5);
        step(5);
        expect_rd("R2 frozen", ra(2, 1), 32'd5);
        wr(ra(2, 1), 32'h1234);
        expect_rd("R9 ro", ra(2, 1), 32'd5);
        wr(12'h000, 32'h0);
        expect_rd("R2 resume0", ra(2, 1), 32'd5);
        step(1);
        expect_rd("R2 resume", ra(2, 1), 32'd4);
        wr(ra(2, 2), 32'h0);

        // R8: channel 0 chain bit ignored
        wr(ra(0, 0), 32'd1);
        wr(ra(0, 2), 32'h7);
        step(1);
        expect_rd("R8 ch0 load", ra(0, 1), 32'd1);
        step(1);
        expect_rd("R8 ch0 free", ra(0, 1), 32'd0);
        wr(ra(0, 2), 32'h0);

        // R8: channel 1 chained to channel 0
        wr(ra(0, 0), 32'd2);
        wr(ra(0, 3), 32'h1);
        wr(ra(1, 0), 32'd1);
        wr(ra(1, 3), 32'h1);
        wr(ra(1, 2), 32'h5);
        wr(ra(0, 2), 32'h1);
        expect_rd("R8 loaded", ra(1, 1), 32'd1);
        step(3);
        expect_rd("R8 hold", ra(1, 1), 32'd1);
        step(1);
        expect_rd("R8 step", ra(1, 1), 32'd0);
        expect_rd("R8 low flag", ra(0, 3), 32'h1);
        step(2);
        expect_rd("R8 hold2", ra(1, 1), 32'd0);
        expect_rd("R8 noflag", ra(1, 3), 32'h0);
        step(1);
        expect_rd("R8 reload", ra(1, 1), 32'd1);
        expect_rd("R8 flag", ra(1, 3), 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule